// File: doc/BRIEF.md
# Dual-Role SPI Controller

A byte-wide serial peripheral for a small register bus that works either as the clock-owning master or as a selected slave. As master, a write to the data register loads the shift register and starts an internal clock generator. The generator produces eight serial clock pulses at a rate chosen from four divider settings and then stops. Each byte is full-duplex: the outgoing bits leave on the data-out line most significant bit first, while the bits arriving from the peer are shifted in behind them. Master and slave together therefore behave as one sixteen-bit ring, and their two bytes are exchanged.

As slave, the block synchronises an external serial clock, data and select into its own clock domain. It shifts only while the select line is low, and it drives its serial output only while selected. Raising select in the middle of a byte throws the partial byte away. Each completed byte is copied into a one-byte read buffer and raises a completion flag, which can also drive an interrupt request. A write made while a byte is still shifting is discarded and noted in a collision bit. The block also gives per-pin hints that force pins to input, according to the mode it is in.

Top module: `spi_dual_role`

## Requirements
- R1: In master mode (control bit 6 enable = 1, bit 4 master = 1), a data write (address 2) while idle starts a transfer. sck_o idles low and first rises half a period after the write edge. The full period in system clocks is 4, 16, 64 or 128 for control bits [1:0] = 0, 1, 2, 3. Exactly eight pulses are produced, then the clock stops. A data write while not enabled starts nothing.
- R2: Outgoing data leaves most significant bit first. mosi_o changes only on falling serial clock edges, and input data is sampled on rising edges.
- R3: A transfer exchanges bytes: the peer receives the written byte, and a data read afterwards returns the byte shifted in from the peer.
- R4: Status bit 7 (flag, address 1) is set in the clock edge that ends the eighth bit. irq_o equals flag AND control bit 7.
- R5: A status read that sees the flag set, followed by any data-register read or write, clears the flag and the collision bit. If a byte completes in the same cycle as that clearing access, the flag stays set.
- R6: A data write while a byte is shifting is ignored, so the transfer continues with the original byte, and it sets status bit 6 (collision).
- R7: The read buffer changes only when a byte completes. If it is not read in time, the next completed byte overwrites it, and a read in the completing cycle still returns the older byte.
- R8: In slave mode (enable = 1, master = 0), the block shifts on sck_i only while ss_ni is low. It sends the loaded byte most significant bit first on miso_o. miso_oe_o is high only while it is selected.
- R9: If ss_ni rises mid-byte in slave mode, the bit count is reset and miso_oe_o drops. The partial byte changes neither the flag nor the read buffer, and the next full byte is received correctly.
- R10: When enabled as master, only force_in_miso_o is high. When enabled as slave, force_in_mosi_o, force_in_sck_o and force_in_ss_o are high and force_in_miso_o is low. When disabled, all four are low.
- R11: The control register at address 0 reads back what was written. After reset, control, status and read buffer are zero, and sck_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock generated in master mode |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe_o | output | 1 | Drive enable for miso_o |
| ss_ni | input | 1 | Active-low slave select |
| force_in_mosi_o | output | 1 | MOSI pin forced to input |
| force_in_miso_o | output | 1 | MISO pin forced to input |
| force_in_sck_o | output | 1 | SCK pin forced to input |
| force_in_ss_o | output | 1 | SS pin forced to input |

## Verification
The critical collision is a byte completing in the same clock edge as the data-register read that would clear the completion flag. The bench arms the clear with a status read while the flag from an earlier byte is still set. It then uses its own cycle model to place a data read exactly on the edge that ends the next byte. It expects the older byte on rdata_o, a flag that stays set afterwards, and the new byte on the following read. A collision write landing mid-transfer is also judged, by the byte the bench's peer actually receives.

// File: rtl/spi_dual_role_pkg.sv
package spi_dual_role_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       rsvd5;
    logic       master;
    logic [1:0] rsvd3_2;
    logic [1:0] div_sel;
  } ctrl_t;

  // half of the serial clock period, in system clocks
  function automatic logic [DIV_W-1:0] half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    half_period = DIV_W'(2);
      2'd1:    half_period = DIV_W'(8);
      2'd2:    half_period = DIV_W'(32);
      default: half_period = DIV_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spi_dual_role_clkgen.sv
module spi_dual_role_clkgen #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == half_i - 1'b1);
  assign rise_o = tick & ~sck_q;
  assign fall_o = tick & sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (start_i || !run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_dual_role_sync.sv
module spi_dual_role_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic ss_ni,
  output logic mosi_o,
  output logic ss_no,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sck_p, mosi_p, ss_p;
  logic              sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p      <= '0;
      mosi_p     <= '0;
      ss_p       <= '1;
      sck_prev_q <= 1'b0;
    end else begin
      sck_p      <= {sck_p[STAGES-2:0], sck_i};
      mosi_p     <= {mosi_p[STAGES-2:0], mosi_i};
      ss_p       <= {ss_p[STAGES-2:0], ss_ni};
      sck_prev_q <= sck_p[STAGES-1];
    end
  end

  assign mosi_o = mosi_p[STAGES-1];
  assign ss_no  = ss_p[STAGES-1];
  assign rise_o = sck_p[STAGES-1] & ~sck_prev_q;
  assign fall_o = ~sck_p[STAGES-1] & sck_prev_q;
endmodule

// File: rtl/spi_dual_role_shift.sv
module spi_dual_role_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         abort_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         in_bit_i,
  output logic         out_bit_o,
  output logic         active_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic          samp_q;
  logic [CW-1:0] cnt_q;

  assign rx_o      = {sh_q[W-2:0], samp_q};
  assign done_o    = fall_i && (cnt_q == CW'(W-1));
  assign out_bit_o = sh_q[W-1];
  assign active_o  = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sh_q  <= load_data_i;
      cnt_q <= '0;
    end else if (abort_i) begin
      cnt_q <= '0;
    end else begin
      if (rise_i) samp_q <= in_bit_i;
      if (fall_i) begin
        sh_q  <= rx_o;
        cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
  import spi_dual_role_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ss_ni,
  output logic              force_in_mosi_o,
  output logic              force_in_miso_o,
  output logic              force_in_sck_o,
  output logic              force_in_ss_o
);
  ctrl_t             ctrl_q;
  logic              flag_q, wcol_q, armed_q, mbusy_q;
  logic [DATA_W-1:0] rx_q;

  logic is_master, is_slave;
  logic data_wr, data_acc, stat_rd, ctrl_wr;
  logic xfer_busy, collide, load, start;
  logic m_rise, m_fall, s_rise, s_fall, mosi_s, ss_s;
  logic rise, fall, in_bit, abort, done, core_active, out_bit;
  logic [DATA_W-1:0] core_rx;

  assign is_master = ctrl_q.enable & ctrl_q.master;
  assign is_slave  = ctrl_q.enable & ~ctrl_q.master;

  assign ctrl_wr  = wr_i && (addr_i == REG_CTRL);
  assign data_wr  = wr_i && (addr_i == REG_DATA);
  assign data_acc = (wr_i || rd_i) && (addr_i == REG_DATA);
  assign stat_rd  = rd_i && (addr_i == REG_STAT);

  assign xfer_busy = mbusy_q | (is_slave & core_active);
  assign collide   = data_wr & xfer_busy;
  assign load      = data_wr & ~xfer_busy & ctrl_q.enable;
  assign start     = load & is_master;

  spi_dual_role_clkgen #(.CNT_W(DIV_W)) i_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (mbusy_q),
    .half_i  (half_period(ctrl_q.div_sel)),
    .sck_o   (sck_o),
    .rise_o  (m_rise),
    .fall_o  (m_fall)
  );

  spi_dual_role_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .ss_ni  (ss_ni),
    .mosi_o (mosi_s),
    .ss_no  (ss_s),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign rise   = is_master ? m_rise : (is_slave & ~ss_s & s_rise);
  assign fall   = is_master ? m_fall : (is_slave & ~ss_s & s_fall);
  assign in_bit = is_master ? miso_i : mosi_s;
  assign abort  = is_slave ? ss_s : ~is_master;

  spi_dual_role_shift #(.W(DATA_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (wdata_i),
    .abort_i     (abort),
    .rise_i      (rise),
    .fall_i      (fall),
    .in_bit_i    (in_bit),
    .out_bit_o   (out_bit),
    .active_o    (core_active),
    .done_o      (done),
    .rx_o        (core_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
      mbusy_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i);
      if (start) mbusy_q <= 1'b1;
      else if (done) mbusy_q <= 1'b0;
      if (done) rx_q <= core_rx;
      // completion outranks the clear sequence
      if (done) flag_q <= 1'b1;
      else if (data_acc && armed_q) flag_q <= 1'b0;
      if (collide) wcol_q <= 1'b1;
      else if (data_acc && armed_q) wcol_q <= 1'b0;
      if (data_acc) armed_q <= 1'b0;
      else if (stat_rd && flag_q) armed_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = {flag_q, wcol_q, 6'b0};
      REG_DATA: rdata_o = rx_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o           = flag_q & ctrl_q.irq_en;
  assign mosi_o          = out_bit;
  assign miso_o          = out_bit;
  assign miso_oe_o       = is_slave & ~ss_s;
  assign force_in_miso_o = is_master;
  assign force_in_mosi_o = is_slave;
  assign force_in_sck_o  = is_slave;
  assign force_in_ss_o   = is_slave;
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sck_o,
  input logic         start,
  input logic         done,
  input logic         is_master,
  input logic         mbusy_q,
  input logic         flag_q,
  input logic         wcol_q,
  input logic         collide,
  input logic [W-1:0] rx_q,
  input logic         ss_ni,
  input logic         miso_oe_o,
  input logic         force_in_miso_o,
  input logic         force_in_sck_o
);
  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (mbusy_q && !sck_o));

  p_sck_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mbusy_q |-> !sck_o);

  p_master_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && is_master) |=> (!mbusy_q && !sck_o));

  p_done_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> flag_q);

  p_wcol_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> wcol_q);

  p_rx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(rx_q));

  p_miso_tristate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ss_ni, SYNC_STAGES) |-> !miso_oe_o);

  p_force_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({force_in_miso_o, force_in_sck_o}));
endmodule

bind spi_dual_role spi_dual_role_chk #(.SYNC_STAGES(SYNC_STAGES), .W(DATA_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sck_o           (sck_o),
  .start           (start),
  .done            (done),
  .is_master       (is_master),
  .mbusy_q         (mbusy_q),
  .flag_q          (flag_q),
  .wcol_q          (wcol_q),
  .collide         (collide),
  .rx_q            (rx_q),
  .ss_ni           (ss_ni),
  .miso_oe_o       (miso_oe_o),
  .force_in_miso_o (force_in_miso_o),
  .force_in_sck_o  (force_in_sck_o)
);

// File: tb/test_spi_dual_role.sv
`timescale 1ns/1ps
module test_spi_dual_role;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, sck_i = 1'b0, sck_o, mosi_i = 1'b0, mosi_o, miso_i, miso_o, miso_oe;
  logic       ss_n = 1'b1;
  logic       f_mosi, f_miso, f_sck, f_ss;

  int n_cmp = 0, n_err = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  spi_dual_role i_spi_dual_role (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe), .ss_ni(ss_n),
    .force_in_mosi_o(f_mosi), .force_in_miso_o(f_miso),
    .force_in_sck_o(f_sck), .force_in_ss_o(f_ss)
  );

  // behavioural peer slave for master-mode tests
  logic [7:0] bslv_out = '0, bslv_rx = '0;
  int nrise = 0;
  assign miso_i = bslv_out[7];
  always @(negedge sck_o) bslv_out <= {bslv_out[6:0], 1'b0};
  always @(posedge sck_o) begin
    bslv_rx <= {bslv_rx[6:0], mosi_o};
    nrise   <= nrise + 1;
  end

  // control settings known to the bench
  bit b_ie = 0, b_en = 0, b_master = 0;
  logic [1:0] b_div = '0;

  function automatic int half_of(input logic [1:0] d);
    return (d == 2'd3) ? 64 : (2 << (2 * d));
  endfunction

  // cycle reference model of the master path and the flag bookkeeping
  bit m_busy, m_sck, m_samp, m_flag, m_wcol, m_armed;
  int m_cnt, m_nfall;
  logic [7:0] m_sh;
  always @(posedge clk or negedge rst_n) begin
    int  h;
    bit  comp, coll, dacc;
    if (!rst_n) begin
      m_busy <= 0; m_sck <= 0; m_samp <= 0; m_flag <= 0; m_wcol <= 0; m_armed <= 0;
      m_cnt <= 0; m_nfall <= 0; m_sh <= '0;
    end else begin
      h = half_of(b_div);
      comp = 0; coll = 0;
      dacc = (wr || rd) && addr == 2'd2;
      if (m_busy) begin
        if (m_cnt == h - 1) begin
          m_cnt <= 0;
          m_sck <= !m_sck;
          if (!m_sck) m_samp <= miso_i;
          else begin
            m_sh <= {m_sh[6:0], m_samp};
            if (m_nfall == 7) begin
              comp = 1; m_busy <= 0; m_nfall <= 0;
            end else m_nfall <= m_nfall + 1;
          end
        end else m_cnt <= m_cnt + 1;
      end
      if (wr && addr == 2'd2) begin
        if (m_busy) coll = 1;
        else if (b_en && b_master) begin
          m_sh <= wdata; m_busy <= 1; m_cnt <= 0; m_sck <= 0; m_nfall <= 0;
        end
      end
      if (comp) m_flag <= 1; else if (dacc && m_armed) m_flag <= 0;
      if (coll) m_wcol <= 1; else if (dacc && m_armed) m_wcol <= 0;
      if (dacc) m_armed <= 0; else if (rd && addr == 2'd1 && m_flag) m_armed <= 1;
    end
  end

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk8("R1 sck_o per clock", {7'b0, sck_o}, {7'b0, m_sck});
    chk8("R2 mosi_o per clock", {7'b0, mosi_o}, {7'b0, m_sh[7]});
    chk8("R4 irq_o per clock", {7'b0, irq}, {7'b0, m_flag & b_ie});
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    b_ie = v[7]; b_en = v[6]; b_master = v[4]; b_div = v[1:0];
    bus_write(2'd0, v);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] sv);
    bslv_out = sv; nrise = 0;
    bus_write(2'd2, tx);
    wait_idle();
  endtask

  task automatic spi_drive(input logic [7:0] tx, input int nbits, output logic [7:0] got);
    got = '0;
    @(negedge clk); ss_n = 0; mosi_i = tx[7];
    repeat (8) @(negedge clk);
    chk8("R8 miso_oe_o while selected", {7'b0, miso_oe}, 8'h01);
    for (int i = 0; i < nbits; i++) begin
      sck_i = 1; got = {got[6:0], miso_o};
      repeat (8) @(negedge clk);
      sck_i = 0;
      if (i < 7) mosi_i = tx[6-i];
      repeat (8) @(negedge clk);
    end
    ss_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic [7:0] v, got;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;

    // R11 reset state
    bus_read(2'd0, v); chk8("R11 ctrl after reset", v, 8'h00);
    bus_read(2'd1, v); chk8("R11 status after reset", v, 8'h00);
    bus_read(2'd2, v); chk8("R11 data after reset", v, 8'h00);
    chk8("R11 sck_o/irq_o after reset", {6'b0, sck_o, irq}, 8'h00);
    chk8("R10 forces when disabled", {4'b0, f_mosi, f_miso, f_sck, f_ss}, 8'h00);

    // R1 write while disabled starts nothing
    nrise = 0;
    bus_write(2'd2, 8'h77);
    repeat (40) @(negedge clk);
    chk8("R1 no clock when disabled", nrise[7:0], 8'h00);

    // master, fastest divider
    set_ctrl(8'hD0);
    bus_read(2'd0, v); chk8("R11 ctrl readback", v, 8'hD0);
    chk8("R10 forces master", {4'b0, f_mosi, f_miso, f_sck, f_ss}, 8'b0100);
    mxfer(8'hA5, 8'h3C);
    chk8("R1 eight pulses", nrise[7:0], 8'd8);
    chk8("R2 peer got MSB-first byte", bslv_rx, 8'hA5);
    chk8("R4 irq_o after byte", {7'b0, irq}, 8'h01);
    bus_read(2'd1, v); chk8("R4 status flag", v, 8'h80);
    bus_read(2'd2, v); chk8("R3 received byte", v, 8'h3C);
    bus_read(2'd1, v); chk8("R5 flag cleared", v, 8'h00);

    // R1 other divider ratios
    for (int d = 1; d < 4; d++) begin
      set_ctrl(8'hD0 | 8'(d));
      mxfer(8'h69 + 8'(d), 8'hE1 - 8'(d));
      chk8("R1 eight pulses per ratio", nrise[7:0], 8'd8);
      chk8("R3 peer byte per ratio", bslv_rx, 8'h69 + 8'(d));
      bus_read(2'd1, v); chk8("R4 flag per ratio", v, 8'h80);
      bus_read(2'd2, v); chk8("R3 rx per ratio", v, 8'hE1 - 8'(d));
    end

    // R6 collision
    set_ctrl(8'hD1);
    bslv_out = 8'h55;
    bus_write(2'd2, 8'h81);
    repeat (20) @(negedge clk);
    bus_write(2'd2, 8'hFF);
    wait_idle();
    chk8("R6 colliding write ignored", bslv_rx, 8'h81);
    bus_read(2'd1, v); chk8("R6 collision bit", v, 8'hC0);
    bus_read(2'd2, v); chk8("R3 rx after collision", v, 8'h55);
    bus_read(2'd1, v); chk8("R5 flag and collision cleared", v, 8'h00);

    // R7 overrun: newest byte wins
    mxfer(8'h11, 8'h22);
    mxfer(8'h33, 8'h44);
    bus_read(2'd2, v); chk8("R7 unread byte overwritten", v, 8'h44);

    // R5 clear access in the completion cycle
    bslv_out = 8'h5A;
    bus_write(2'd2, 8'hC3);
    bus_read(2'd1, v); chk8("R5 status before race", v, 8'h80);
    h = half_of(b_div);
    while (!(m_busy && m_cnt == h - 1 && m_sck && m_nfall == 7)) @(negedge clk);
    addr = 2'd2; rd = 1; #1 v = rdata;
    chk8("R7 read in completing cycle returns old byte", v, 8'h44);
    @(negedge clk); rd = 0;
    chk8("R5 completion beats clear", {7'b0, irq}, 8'h01);
    bus_read(2'd1, v); chk8("R5 flag still set", v, 8'h80);
    bus_read(2'd2, v); chk8("R7 new byte", v, 8'h5A);
    bus_read(2'd1, v); chk8("R5 flag cleared after race", v, 8'h00);

    // slave mode
    cmp_on = 0;
    set_ctrl(8'hC0);
    chk8("R10 forces slave", {4'b0, f_mosi, f_miso, f_sck, f_ss}, 8'b1011);
    chk8("R8 miso_oe_o low when deselected", {7'b0, miso_oe}, 8'h00);
    bus_write(2'd2, 8'h6B);
    spi_drive(8'h92, 8, got);
    chk8("R8 slave sent MSB-first byte", got, 8'h6B);
    chk8("R4 irq_o slave byte", {7'b0, irq}, 8'h01);
    bus_read(2'd1, v); chk8("R4 slave flag", v, 8'h80);
    bus_read(2'd2, v); chk8("R3 slave received byte", v, 8'h92);
    bus_read(2'd1, v); chk8("R5 slave flag cleared", v, 8'h00);

    // R9 deselect mid-byte
    bus_write(2'd2, 8'hF0);
    spi_drive(8'hAA, 3, got);
    bus_read(2'd1, v); chk8("R9 partial byte sets no flag", v, 8'h00);
    chk8("R9 miso_oe_o dropped", {7'b0, miso_oe}, 8'h00);
    bus_read(2'd2, v); chk8("R9 read buffer kept", v, 8'h92);
    bus_write(2'd2, 8'h0F);
    spi_drive(8'h47, 8, got);
    chk8("R9 next byte sent", got, 8'h0F);
    bus_read(2'd1, v); chk8("R9 next byte flag", v, 8'h80);
    bus_read(2'd2, v); chk8("R9 next byte received", v, 8'h47);

    summary();
  end
endmodule